// File: doc/BRIEF.md
# Serial Port with Debug-Halt Control

This block is a synchronous serial port with one transmit and one receive section that share a locally generated bit clock. Software hands the transmitter one parallel word at a time through a valid/ready handshake. The word goes to a holding register, is shifted out most significant bit first, and a one-bit-long frame pulse marks its first bit. The receiver samples serial data on the opposite bit-clock phase. It starts a word when it sees the frame pulse and presents the finished word with a ready flag. It flags an overrun when a word completes before the previous one was read. It flags a sync error when a frame pulse arrives in the middle of a word.

A halt-request input stands for a debugger breakpoint. Two configuration bits, free and soft, decide the reaction to it, and both come out of reset as 0:

- **Free set:** the halt is ignored.
- **Both clear:** the bit clock freezes at once and any word in flight is dropped.
- **Soft set, free clear:** the transmitter finishes its current word and then starts no new one. The receiver keeps running, so overruns stay possible.

Separate transmitter and receiver reset inputs return each side to its initial state. While the transmitter is in reset, its data pin is released and its frame output sits at the inactive level. The bit clock keeps running through either reset.

Top module: `sph_port`

## Requirements
- R1: After `rst`, the free and soft mode bits are 0, `tx_ready`=1, `tx_empty`=1, `rx_ready`=0, `rx_overrun`=0, `rx_sync_err`=0, and `fsx_out` sits at its inactive level 1.
- R2: A transmit word is sent MSB first. `fsx_out` is at its active level for exactly one bit period (2*BCLK_HALF clock cycles), aligned with the first bit. When `dx_out`/`fsx_out` are looped back to `dr_in`/`fsr_in`, `rx_data` equals the sent word and `rx_ready` is set.
- R3: With the free bit at 1, `halt_req` has no effect: the bit clock keeps toggling and words keep flowing.
- R4: With free=0 and soft=0, `halt_req` freezes the bit clock while it is held. A word in flight is abandoned: `tx_empty` returns to 1, `fsx_out` goes inactive and `dx_out` goes to 0. After release, the next word starts with a fresh frame.
- R5: With free=0 and soft=1, `halt_req` lets the current transmit word finish, then no new word starts while the halt is held. A queued word stays pending (`tx_ready`=0), and the receiver keeps clocking and receiving.
- R6: A word that completes while `rx_ready` is still 1 (and is not being read in that cycle) sets `rx_overrun`. The new word replaces `rx_data`, and `rx_overrun` stays set until a receiver reset.
- R7: A receive frame pulse that arrives while a word is partly received sets `rx_sync_err`, and reception restarts from that frame. The flag stays set until a receiver reset.
- R8: While `tx_rst`=1: `dx_oe`=0, `fsx_out` is at the inactive level, `tx_ready`=1 and `tx_empty`=1, the word in flight is discarded, and `bclk_out` keeps toggling.
- R9: `rx_rst` clears `rx_ready`, `rx_overrun`, `rx_sync_err` and any partly received word.
- R10: `cfg_wr` loads four configuration bits: free, soft, clock polarity and frame polarity. `bclk_out` is the internal bit clock inverted when the clock-polarity bit is 1. The frame active level equals the frame-polarity bit, and the inactive level is its inverse.
- R11: A one-cycle `rx_read` pulse clears `rx_ready` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| tx_rst | input | 1 | Transmitter reset, active high |
| rx_rst | input | 1 | Receiver reset, active high |
| halt_req | input | 1 | Debugger breakpoint request |
| cfg_wr | input | 1 | Load strobe for the four configuration bits |
| cfg_free | input | 1 | Free-run bit |
| cfg_soft | input | 1 | Soft-stop bit |
| cfg_clkpol | input | 1 | Bit clock output inversion |
| cfg_fspol | input | 1 | Frame active level |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register free |
| tx_empty | output | 1 | No word being shifted |
| rx_data | output | WORD_W | Last received word |
| rx_ready | output | 1 | Received word available |
| rx_read | input | 1 | Acknowledge of the received word |
| rx_overrun | output | 1 | Sticky overrun flag |
| rx_sync_err | output | 1 | Sticky frame-in-word flag |
| bclk_out | output | 1 | Bit clock pin |
| dx_out | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Transmit data output enable |
| fsx_out | output | 1 | Transmit frame pulse |
| dr_in | input | 1 | Serial receive data |
| fsr_in | input | 1 | Receive frame pulse |

## Verification
The bench builds the port with WORD_W=12 and BCLK_HALF=3. A 12-bit word does not divide evenly into bytes, and a half period of three cycles makes the divider wrap at a value that is not a power of two. Each bit lasts six cycles, which leaves room to raise the halt in the middle of a word, to drive a stray frame pulse on chosen bit positions, and to watch the clock freeze and re-invert under a polarity write. Loopback of the serial pins feeds a scoreboard, so abort, soft finish and free-run behaviour all show up as received words that are either missing or present.

// File: rtl/sph_pkg.sv
package sph_pkg;
  typedef enum logic [1:0] {
    HM_RUN    = 2'd0,
    HM_FINISH = 2'd1,
    HM_ABORT  = 2'd2
  } halt_mode_e;

  function automatic halt_mode_e halt_mode(input logic free_b, input logic soft_b);
    if (free_b) return HM_RUN;
    else if (soft_b) return HM_FINISH;
    else return HM_ABORT;
  endfunction
endpackage

// File: rtl/sph_bitclk.sv
module sph_bitclk #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  output logic bclk,
  output logic rise_tick,
  output logic fall_tick
);
  logic wrap;

  generate
    if (HALF == 1) begin : g_direct
      assign wrap = !freeze;
    end else begin : g_count
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (!freeze) cnt <= (cnt == CW'(HALF-1)) ? '0 : cnt + CW'(1);
      end
      assign wrap = !freeze && (cnt == CW'(HALF-1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) bclk <= 1'b0;
    else if (wrap) bclk <= !bclk;
  end

  assign rise_tick = wrap && !bclk;
  assign fall_tick = wrap && bclk;
endmodule

// File: rtl/sph_tx.sv
module sph_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fall_tick,
  input  logic         abort,
  input  logic         hold_off,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  output logic         empty,
  output logic         dx,
  output logic         fs_act
);
  localparam int CW = $clog2(W);
  logic [W-1:0]  hold_q, sh_q;
  logic          hold_v, busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0; sh_q <= '0; hold_v <= 1'b0; busy <= 1'b0;
      cnt <= '0; dx <= 1'b0; fs_act <= 1'b0;
    end else begin
      if (abort) begin
        busy <= 1'b0; fs_act <= 1'b0; dx <= 1'b0; cnt <= '0;
      end else if (fall_tick) begin
        if (busy && cnt != CW'(W-1)) begin
          sh_q   <= sh_q << 1;
          dx     <= sh_q[W-2];
          cnt    <= cnt + CW'(1);
          fs_act <= 1'b0;
        end else if (hold_v && !hold_off) begin
          sh_q   <= hold_q;
          dx     <= hold_q[W-1];
          fs_act <= 1'b1;
          busy   <= 1'b1;
          cnt    <= '0;
          hold_v <= 1'b0;
        end else begin
          busy <= 1'b0; dx <= 1'b0; fs_act <= 1'b0;
        end
      end
      if (wr_valid && !hold_v) begin
        hold_q <= wr_data;
        hold_v <= 1'b1;
      end
    end
  end

  assign wr_ready = !hold_v;
  assign empty    = !busy;
endmodule

// File: rtl/sph_rx.sv
module sph_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise_tick,
  input  logic         dr,
  input  logic         fs,
  input  logic         rd,
  output logic [W-1:0] data,
  output logic         ready,
  output logic         overrun,
  output logic         sync_err
);
  localparam int CW = $clog2(W);
  logic [W-1:0]  sh_q, nxt;
  logic          busy;
  logic [CW-1:0] cnt;

  assign nxt = {sh_q[W-2:0], dr};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0; data <= '0; busy <= 1'b0; cnt <= '0;
      ready <= 1'b0; overrun <= 1'b0; sync_err <= 1'b0;
    end else begin
      if (rd) ready <= 1'b0;
      if (rise_tick) begin
        if (fs) begin
          if (busy) sync_err <= 1'b1;
          sh_q <= nxt;
          cnt  <= CW'(1);
          busy <= 1'b1;
        end else if (busy) begin
          sh_q <= nxt;
          cnt  <= cnt + CW'(1);
          if (cnt == CW'(W-1)) begin
            data <= nxt;
            busy <= 1'b0;
            if (ready && !rd) overrun <= 1'b1;
            ready <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sph_port.sv
module sph_port #(
  parameter int WORD_W    = 8,
  parameter int BCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_rst,
  input  logic              rx_rst,
  input  logic              halt_req,
  input  logic              cfg_wr,
  input  logic              cfg_free,
  input  logic              cfg_soft,
  input  logic              cfg_clkpol,
  input  logic              cfg_fspol,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_empty,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              rx_read,
  output logic              rx_overrun,
  output logic              rx_sync_err,
  output logic              bclk_out,
  output logic              dx_out,
  output logic              dx_oe,
  output logic              fsx_out,
  input  logic              dr_in,
  input  logic              fsr_in
);
  import sph_pkg::*;

  logic mode_free, mode_soft, mode_clkpol, mode_fspol;
  halt_mode_e hmode;
  logic stop_new, abort_now;
  logic bclk_int, rise_tick, fall_tick;
  logic tx_dx, tx_fs;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_free <= 1'b0; mode_soft <= 1'b0; mode_clkpol <= 1'b0; mode_fspol <= 1'b0;
    end else if (cfg_wr) begin
      mode_free <= cfg_free; mode_soft <= cfg_soft;
      mode_clkpol <= cfg_clkpol; mode_fspol <= cfg_fspol;
    end
  end

  assign hmode     = halt_mode(mode_free, mode_soft);
  assign stop_new  = halt_req && (hmode != HM_RUN);
  assign abort_now = halt_req && (hmode == HM_ABORT);

  sph_bitclk #(.HALF(BCLK_HALF)) u_clk (
    .clk(clk), .rst(rst), .freeze(abort_now),
    .bclk(bclk_int), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  sph_tx #(.W(WORD_W)) u_tx (
    .clk(clk), .rst(rst || tx_rst), .fall_tick(fall_tick),
    .abort(abort_now), .hold_off(stop_new),
    .wr_valid(tx_valid), .wr_data(tx_data), .wr_ready(tx_ready),
    .empty(tx_empty), .dx(tx_dx), .fs_act(tx_fs)
  );

  sph_rx #(.W(WORD_W)) u_rx (
    .clk(clk), .rst(rst || rx_rst), .rise_tick(rise_tick),
    .dr(dr_in), .fs(fsr_in == mode_fspol), .rd(rx_read),
    .data(rx_data), .ready(rx_ready), .overrun(rx_overrun), .sync_err(rx_sync_err)
  );

  // pin stage: all serial outputs leave through one register
  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_out <= 1'b0; dx_out <= 1'b0; dx_oe <= 1'b0; fsx_out <= 1'b1;
    end else begin
      bclk_out <= bclk_int ^ mode_clkpol;
      dx_oe    <= !tx_rst;
      dx_out   <= tx_rst ? 1'b0 : tx_dx;
      fsx_out  <= (tx_fs && !tx_rst) ? mode_fspol : !mode_fspol;
    end
  end
endmodule

// File: rtl/sph_port_chk.sv
module sph_port_chk (
  input logic clk,
  input logic rst,
  input logic tx_rst,
  input logic rx_rst,
  input logic halt_req,
  input logic cfg_wr,
  input logic mode_free,
  input logic mode_soft,
  input logic mode_fspol,
  input logic bclk_int,
  input logic tx_ready,
  input logic tx_empty,
  input logic rx_ready,
  input logic rx_overrun,
  input logic rx_sync_err,
  input logic dx_oe,
  input logic fsx_out
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_ready && tx_empty && !rx_ready && !rx_overrun && !rx_sync_err));

  assert_abort_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !mode_free && !mode_soft) |=> $stable(bclk_int));

  assert_no_new_word_R5: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !mode_free && tx_empty) |=> tx_empty);

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !rx_rst) |=> rx_overrun);

  assert_sync_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_sync_err && !rx_rst) |=> rx_sync_err);

  assert_tx_reset_pins_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_rst && !cfg_wr) |=> (!dx_oe && tx_ready && tx_empty && (fsx_out == !mode_fspol)));

  assert_rx_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    rx_rst |=> (!rx_ready && !rx_overrun && !rx_sync_err));
endmodule

bind sph_port sph_port_chk u_chk (
  .clk(clk), .rst(rst), .tx_rst(tx_rst), .rx_rst(rx_rst), .halt_req(halt_req),
  .cfg_wr(cfg_wr), .mode_free(mode_free), .mode_soft(mode_soft), .mode_fspol(mode_fspol),
  .bclk_int(bclk_int), .tx_ready(tx_ready), .tx_empty(tx_empty), .rx_ready(rx_ready),
  .rx_overrun(rx_overrun), .rx_sync_err(rx_sync_err), .dx_oe(dx_oe), .fsx_out(fsx_out)
);

// File: tb/sph_port_tb_top.sv
module sph_port_tb_top;
  localparam int W    = 12;
  localparam int HALF = 3;
  localparam int BIT  = 2 * HALF;

  logic clk = 1'b0;
  logic rst = 1'b1, tx_rst = 1'b0, rx_rst = 1'b0, halt_req = 1'b0;
  logic cfg_wr = 1'b0, cfg_free = 1'b0, cfg_soft = 1'b0, cfg_clkpol = 1'b0, cfg_fspol = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic tx_valid = 1'b0, rx_read = 1'b0;
  logic tx_ready, tx_empty, rx_ready, rx_overrun, rx_sync_err;
  logic [W-1:0] rx_data;
  logic bclk_out, dx_out, dx_oe, fsx_out;
  logic lb = 1'b1, man_dr = 1'b0, man_fs = 1'b1;
  logic dr_in, fsr_in;

  assign dr_in  = lb ? dx_out  : man_dr;
  assign fsr_in = lb ? fsx_out : man_fs;

  always #2 clk = ~clk;

  sph_port #(.WORD_W(W), .BCLK_HALF(HALF)) dut_i (
    .clk(clk), .rst(rst), .tx_rst(tx_rst), .rx_rst(rx_rst), .halt_req(halt_req),
    .cfg_wr(cfg_wr), .cfg_free(cfg_free), .cfg_soft(cfg_soft),
    .cfg_clkpol(cfg_clkpol), .cfg_fspol(cfg_fspol),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_empty(tx_empty),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_read(rx_read),
    .rx_overrun(rx_overrun), .rx_sync_err(rx_sync_err),
    .bclk_out(bclk_out), .dx_out(dx_out), .dx_oe(dx_oe), .fsx_out(fsx_out),
    .dr_in(dr_in), .fsr_in(fsr_in)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  bit mon_en = 1'b0;
  logic [W-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard whenever a word is presented
  initial begin
    forever begin
      @(negedge clk);
      rx_read = 1'b0;
      if (mon_en && rx_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected received word", rx_data, 0);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R2 received word", rx_data, e);
        end
        rx_read = 1'b1;
      end
    end
  end

  // driver: offer a word, optionally record it as expected
  task automatic send(input logic [W-1:0] w, input bit expect_it);
    int guard = 0;
    @(negedge clk);
    while (!tx_ready && guard < 2000) begin @(negedge clk); guard++; end
    tx_data = w; tx_valid = 1'b1;
    if (expect_it) exp_q.push_back(w);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_drain(input int max_cyc);
    for (int i = 0; i < max_cyc && exp_q.size() != 0; i++) @(negedge clk);
  endtask

  task automatic pulse_rx_rst();
    @(negedge clk); rx_rst = 1'b1;
    @(negedge clk); rx_rst = 1'b0;
  endtask

  task automatic set_cfg(input bit f, input bit s, input bit cp, input bit fp);
    @(negedge clk);
    cfg_free = f; cfg_soft = s; cfg_clkpol = cp; cfg_fspol = fp; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    repeat (2) @(negedge clk);
    pulse_rx_rst();
  endtask

  task automatic count_bclk_edges(input int cyc, output int edges);
    logic prev;
    edges = 0;
    @(negedge clk); prev = bclk_out;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (bclk_out != prev) edges++;
      prev = bclk_out;
    end
  endtask

  task automatic man_bit(input bit fs_on, input bit d);
    @(negedge bclk_out);
    @(negedge clk);
    man_fs = !fs_on;
    man_dr = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    int edges, fs_cnt;
    logic frozen;
    logic [W-1:0] pat;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R1 tx_ready after reset", tx_ready, 1);
    chk(tx_empty == 1'b1, "R1 tx_empty after reset", tx_empty, 1);
    chk(rx_ready == 1'b0 && rx_overrun == 1'b0 && rx_sync_err == 1'b0,
        "R1 receive flags after reset", {rx_ready, rx_overrun, rx_sync_err}, 0);
    chk(fsx_out == 1'b1, "R1 frame idle level", fsx_out, 1);
    @(negedge clk);
    chk(dx_oe == 1'b1, "R8 data driven out of tx reset", dx_oe, 1);

    // R2: loopback of several words, one frame bit per word
    mon_en = 1'b1;
    send(12'hA5C, 1'b1);
    fs_cnt = 0;
    for (int i = 0; i < 20 * BIT; i++) begin
      @(negedge clk);
      if (fsx_out == 1'b0) fs_cnt++;
    end
    chk(fs_cnt == BIT, "R2 frame pulse length", fs_cnt, BIT);
    chk(exp_q.size() == 0, "R2 first word received", exp_q.size(), 0);
    send(12'hFFF, 1'b1); send(12'h000, 1'b1); send(12'h801, 1'b1); send(12'h3C6, 1'b1);
    wait_drain(3000);
    chk(exp_q.size() == 0, "R2 back-to-back words drained", exp_q.size(), 0);
    chk(rx_sync_err == 1'b0, "R2 no sync error on back-to-back frames", rx_sync_err, 0);

    // R10: inverted polarities
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1);
    chk(fsx_out == 1'b0, "R10 inverse idle frame level", fsx_out, 0);
    send(12'h5A3, 1'b1);
    wait_drain(2000);
    chk(exp_q.size() == 0, "R10 word with inverted polarity", exp_q.size(), 0);
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0);

    // R3: free run ignores halt
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk); halt_req = 1'b1;
    send(12'h123, 1'b1); send(12'hEDC, 1'b1);
    count_bclk_edges(40, edges);
    chk(edges >= 10, "R3 bit clock toggles during halt", edges, 13);
    wait_drain(3000);
    chk(exp_q.size() == 0, "R3 words flow during halt", exp_q.size(), 0);
    @(negedge clk); halt_req = 1'b0;

    // R4: immediate stop aborts the word
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
    send(12'h9E7, 1'b0);
    while (tx_empty) @(negedge clk);
    repeat (3 * BIT) @(negedge clk);
    halt_req = 1'b1;
    repeat (3) @(negedge clk);
    frozen = bclk_out;
    chk(tx_empty == 1'b1, "R4 word abandoned", tx_empty, 1);
    chk(fsx_out == 1'b1 && dx_out == 1'b0, "R4 pins idle after abort", {fsx_out, dx_out}, 2);
    chk(tx_ready == 1'b1, "R4 ready again after abort", tx_ready, 1);
    count_bclk_edges(40, edges);
    chk(edges == 0 && bclk_out == frozen, "R4 bit clock frozen", edges, 0);
    @(negedge clk);
    cfg_free = 1'b0; cfg_soft = 1'b0; cfg_clkpol = 1'b1; cfg_fspol = 1'b0; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk(bclk_out == !frozen, "R10 clock polarity inverts pin", bclk_out, !frozen);
    cfg_clkpol = 1'b0; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    pulse_rx_rst();
    chk(rx_ready == 1'b0 && rx_sync_err == 1'b0, "R9 receiver cleared", {rx_ready, rx_sync_err}, 0);
    @(negedge clk); halt_req = 1'b0;
    send(12'h4B2, 1'b1);
    wait_drain(2000);
    chk(exp_q.size() == 0, "R4 clean word after release", exp_q.size(), 0);
    chk(rx_sync_err == 1'b0, "R4 fresh frame after release", rx_sync_err, 0);

    // R5: soft stop finishes current word only
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0);
    send(12'h6D1, 1'b1);
    while (tx_empty) @(negedge clk);
    repeat (BIT) @(negedge clk);
    halt_req = 1'b1;
    send(12'h2F8, 1'b1);
    for (int i = 0; i < 2000 && exp_q.size() > 1; i++) @(negedge clk);
    chk(exp_q.size() == 1, "R5 current word completed under halt", exp_q.size(), 1);
    repeat (30 * BIT) @(negedge clk);
    chk(exp_q.size() == 1, "R5 queued word held back", exp_q.size(), 1);
    chk(tx_ready == 1'b0 && tx_empty == 1'b1, "R5 word pending, shifter idle", {tx_ready, tx_empty}, 1);
    count_bclk_edges(30, edges);
    chk(edges >= 8, "R5 receiver clock keeps running", edges, 10);
    @(negedge clk); halt_req = 1'b0;
    wait_drain(2000);
    chk(exp_q.size() == 0, "R5 held word sent after release", exp_q.size(), 0);

    // R6 / R11: overrun without reading
    mon_en = 1'b0;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
    send(12'h111, 1'b0); send(12'hB0D, 1'b0);
    for (int i = 0; i < 2000 && !(tx_empty && tx_ready); i++) @(negedge clk);
    repeat (4 * BIT) @(negedge clk);
    chk(rx_overrun == 1'b1, "R6 overrun flagged", rx_overrun, 1);
    chk(rx_data == 12'hB0D, "R6 newest word kept", rx_data, 12'hB0D);
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
    chk(rx_ready == 1'b0, "R11 read clears ready", rx_ready, 0);
    chk(rx_overrun == 1'b1, "R6 overrun sticky after read", rx_overrun, 1);
    pulse_rx_rst();
    chk(rx_overrun == 1'b0, "R9 overrun cleared by receiver reset", rx_overrun, 0);

    // R7: stray frame mid-word
    lb = 1'b0;
    man_bit(1'b1, 1'b1); man_bit(1'b0, 1'b0); man_bit(1'b0, 1'b1);
    man_bit(1'b0, 1'b1);
    chk(rx_sync_err == 1'b0, "R7 no error on partial word", rx_sync_err, 0);
    pat = 12'hC35;
    for (int b = W - 1; b >= 0; b--) man_bit(b == W - 1, pat[b]);
    man_bit(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk(rx_sync_err == 1'b1, "R7 sync error flagged", rx_sync_err, 1);
    chk(rx_ready == 1'b1 && rx_data == pat, "R7 reception restarted on frame", rx_data, pat);
    repeat (5 * BIT) @(negedge clk);
    chk(rx_sync_err == 1'b1, "R7 sync error sticky", rx_sync_err, 1);
    pulse_rx_rst();
    chk(rx_sync_err == 1'b0 && rx_ready == 1'b0, "R9 sync error cleared", {rx_sync_err, rx_ready}, 0);
    lb = 1'b1;

    // R8: transmitter reset mid-word
    send(12'h7A7, 1'b0);
    while (tx_empty) @(negedge clk);
    repeat (2 * BIT) @(negedge clk);
    tx_rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(dx_oe == 1'b0, "R8 data pin released", dx_oe, 0);
    chk(fsx_out == 1'b1, "R8 frame inactive in reset", fsx_out, 1);
    chk(tx_ready == 1'b1 && tx_empty == 1'b1, "R8 transmit status reset", {tx_ready, tx_empty}, 3);
    count_bclk_edges(30, edges);
    chk(edges >= 8, "R8 bit clock runs in reset", edges, 10);
    @(negedge clk); tx_rst = 1'b0;
    pulse_rx_rst();
    mon_en = 1'b1;
    send(12'h0F0, 1'b1);
    wait_drain(2000);
    chk(exp_q.size() == 0, "R8 word after tx reset", exp_q.size(), 0);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule